// File: doc/BRIEF.md
# Passive LCD line timing generator

This block sequences the horizontal timing of a passive matrix display, one line after another, from a single system clock. It builds a pixel-clock enable by dividing the system clock by two and then by a programmable factor. It steps a four-state machine once per pixel clock. Each line runs through four phases in order:

1. A quiet lead-in.
2. A window of pixel output, flagged by `data_act`.
3. A quiet guard interval.
4. The line pulse.

A lines-per-frame count marks the last line of a frame. The line pulse of that line also raises `frame_mark`, which tells the panel that the next line is the first line of a new frame.

The six configuration inputs are held in a shadow set. The shadow is loaded at reset and again on the final pixel clock of the last line pulse of each frame, so every line of a frame uses one coherent set of settings. The states are `ST_LEAD` (wait before data), `ST_DATA`, `ST_TRAIL` (wait before the pulse) and `ST_PULSE`. The transitions are:

- lead-done: `ST_LEAD` to `ST_DATA`.
- data-done: `ST_DATA` to `ST_TRAIL`, or straight to `ST_PULSE` when the trailing wait is 0.
- trail-done: `ST_TRAIL` to `ST_PULSE`.
- pulse-done: `ST_PULSE` to `ST_LEAD`, or straight to `ST_DATA` when the lead wait that applies to the next line is 0.

Top module: `lcd_line_timer`

## Requirements
- R1: `pix_ce` is high for exactly one system clock in every 2*(`cfg_div`+1) system clocks, and never on two consecutive clocks.
- R2: During reset and in the cycle after it, `line_pulse`, `frame_mark` and `data_act` are all low. Line 0 then begins in `ST_LEAD`, which lasts max(`cfg_wait_post`,1) pixel clocks.
- R3: `data_act` is high for `cfg_xmax` consecutive pixel clocks per line. A value of 0 is treated as 1.
- R4: After the data window, `cfg_wait_pre` pixel clocks pass with all outputs low before `line_pulse` rises. With 0, the pulse follows the data at once.
- R5: `line_pulse` stays high for `cfg_pulse_w` pixel clocks. A value of 0 is treated as 1.
- R6: After the pulse, `cfg_wait_post` pixel clocks pass with all outputs low before the next line's data starts. With 0, the data follows the pulse at once.
- R7: Lines are numbered from 0. `frame_mark` is high exactly during the pulse of line `cfg_lines`-1, with a `cfg_lines` of 0 treated as 1, and never outside `line_pulse`.
- R8: Configuration inputs take effect only at reset and at the end of the last pulse of a frame. Changes made at any other time do not alter the frame in progress. The new divider setting governs from the first pixel clock of the new frame.
- R9: `line_pulse` and `data_act` are never high together. All three timing outputs change only on a system clock edge at which `pix_ce` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also loads the configuration shadow |
| cfg_xmax | input | XW | Pixels per line |
| cfg_wait_pre | input | WW | Pixel clocks between end of data and start of the pulse |
| cfg_pulse_w | input | PW | Line pulse width in pixel clocks |
| cfg_wait_post | input | WW | Pixel clocks between end of the pulse and start of data |
| cfg_lines | input | LW | Lines per frame |
| cfg_div | input | DW | Pixel clock divider; period is 2*(cfg_div+1) system clocks |
| pix_ce | output | 1 | One-cycle pixel clock enable |
| line_pulse | output | 1 | Line pulse |
| frame_mark | output | 1 | First-line marker, high during the last pulse of a frame |
| data_act | output | 1 | Data output window of the current line |

## Verification
Two actions share the final pixel clock of a frame's last pulse: the frame reload of the shadow registers, and the pulse-done transition, whose target state is chosen from the incoming lead wait. The divider also wraps on that same edge. To provoke this, the bench rewrites every configuration input shortly after each frame starts, using mixed directed and random values that include zero waits and zero widths. It then compares the output stream, one pixel clock at a time, with a sequence built from the settings captured at the boundary. A reload in the wrong cycle, or a skip decision made on stale values, shows up as a phase of the wrong length in the next frame's first line. It also shows up as a wrong pixel-clock period on that frame's first tick.

// File: rtl/lcd_line_pkg.sv
package lcd_line_pkg;

    // Phases of one display line, in the order they are visited
    typedef enum logic [1:0] {
        ST_LEAD  = 2'd0,
        ST_DATA  = 2'd1,
        ST_TRAIL = 2'd2,
        ST_PULSE = 2'd3
    } line_state_e;

endpackage

// File: rtl/lcd_pix_div.sv
module lcd_pix_div #(
    parameter int DW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] div,
    output logic          pix_ce
);
    localparam int CW = DW + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    // terminal count 2*(div+1)-1
    assign last = {div, 1'b1};

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt >= last)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign pix_ce = (cnt == last);

endmodule

// File: rtl/lcd_cfg_shadow.sv
module lcd_cfg_shadow #(
    parameter int XW = 10,
    parameter int WW = 8,
    parameter int PW = 8,
    parameter int LW = 10,
    parameter int DW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [XW-1:0] in_xmax,
    input  logic [WW-1:0] in_wait_pre,
    input  logic [PW-1:0] in_pulse_w,
    input  logic [WW-1:0] in_wait_post,
    input  logic [LW-1:0] in_lines,
    input  logic [DW-1:0] in_div,
    output logic [XW-1:0] sh_xmax,
    output logic [WW-1:0] sh_wait_pre,
    output logic [PW-1:0] sh_pulse_w,
    output logic [WW-1:0] sh_wait_post,
    output logic [LW-1:0] sh_lines,
    output logic [DW-1:0] sh_div,
    output logic [WW-1:0] nx_wait_post
);
    always_ff @(posedge clk) begin
        if (rst || load) begin
            sh_xmax      <= in_xmax;
            sh_wait_pre  <= in_wait_pre;
            sh_pulse_w   <= in_pulse_w;
            sh_wait_post <= in_wait_post;
            sh_lines     <= in_lines;
            sh_div       <= in_div;
        end
    end

    // lead wait that the line after the current pulse will use
    assign nx_wait_post = load ? in_wait_post : sh_wait_post;

endmodule

// File: rtl/lcd_line_fsm.sv
module lcd_line_fsm
    import lcd_line_pkg::*;
#(
    parameter int XW = 10,
    parameter int WW = 8,
    parameter int PW = 8,
    parameter int LW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pix_ce,
    input  logic [XW-1:0] xmax,
    input  logic [WW-1:0] wait_pre,
    input  logic [PW-1:0] pulse_w,
    input  logic [WW-1:0] wait_post,
    input  logic [LW-1:0] lines,
    input  logic [WW-1:0] nx_wait_post,
    output logic          frame_end,
    output logic          line_pulse,
    output logic          frame_mark,
    output logic          data_act
);
    localparam int CW0 = (XW > WW) ? XW : WW;
    localparam int CW  = (CW0 > PW) ? CW0 : PW;
    localparam int LCW = CW + 1;

    line_state_e   state, nstate;
    logic [CW-1:0] cnt;
    logic [LW-1:0] line;
    logic [LW-1:0] lines1;
    logic [LCW-1:0] len;
    logic [LCW-1:0] cnt_inc;
    logic          done;
    logic          last_line;

    // length of the current phase in pixel clocks
    always_comb begin
        unique case (state)
            ST_LEAD:  len = LCW'(wait_post);
            ST_DATA:  len = (xmax == '0) ? LCW'(1) : LCW'(xmax);
            ST_TRAIL: len = LCW'(wait_pre);
            ST_PULSE: len = (pulse_w == '0) ? LCW'(1) : LCW'(pulse_w);
            default:  len = '0;
        endcase
    end

    assign cnt_inc   = {1'b0, cnt} + 1'b1;
    assign done      = pix_ce && (cnt_inc >= len);
    assign lines1    = (lines == '0) ? LW'(1) : lines;
    assign last_line = (line == lines1 - LW'(1));
    assign frame_end = done && (state == ST_PULSE) && last_line;

    // transitions, with zero-length guard waits skipped
    always_comb begin
        nstate = state;
        if (done) begin
            unique case (state)
                ST_LEAD:  nstate = ST_DATA;
                ST_DATA:  nstate = (wait_pre == '0) ? ST_PULSE : ST_TRAIL;
                ST_TRAIL: nstate = ST_PULSE;
                ST_PULSE: nstate = (nx_wait_post == '0) ? ST_DATA : ST_LEAD;
                default:  nstate = ST_LEAD;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_LEAD;
            cnt   <= '0;
            line  <= '0;
        end else if (pix_ce) begin
            if (done) begin
                state <= nstate;
                cnt   <= '0;
                if (state == ST_PULSE)
                    line <= last_line ? '0 : line + LW'(1);
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        line_pulse = (state == ST_PULSE);
        frame_mark = (state == ST_PULSE) && last_line;
        data_act   = (state == ST_DATA);
    end

endmodule

// File: rtl/lcd_line_timer.sv
module lcd_line_timer #(
    parameter int XW = 10,
    parameter int WW = 8,
    parameter int PW = 8,
    parameter int LW = 10,
    parameter int DW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [XW-1:0] cfg_xmax,
    input  logic [WW-1:0] cfg_wait_pre,
    input  logic [PW-1:0] cfg_pulse_w,
    input  logic [WW-1:0] cfg_wait_post,
    input  logic [LW-1:0] cfg_lines,
    input  logic [DW-1:0] cfg_div,
    output logic          pix_ce,
    output logic          line_pulse,
    output logic          frame_mark,
    output logic          data_act
);
    logic [XW-1:0] sh_xmax;
    logic [WW-1:0] sh_wait_pre;
    logic [PW-1:0] sh_pulse_w;
    logic [WW-1:0] sh_wait_post;
    logic [LW-1:0] sh_lines;
    logic [DW-1:0] sh_div;
    logic [WW-1:0] nx_wait_post;
    logic          frame_end;

    lcd_cfg_shadow #(.XW(XW), .WW(WW), .PW(PW), .LW(LW), .DW(DW)) u_shadow (
        .clk          (clk),
        .rst          (rst),
        .load         (frame_end),
        .in_xmax      (cfg_xmax),
        .in_wait_pre  (cfg_wait_pre),
        .in_pulse_w   (cfg_pulse_w),
        .in_wait_post (cfg_wait_post),
        .in_lines     (cfg_lines),
        .in_div       (cfg_div),
        .sh_xmax      (sh_xmax),
        .sh_wait_pre  (sh_wait_pre),
        .sh_pulse_w   (sh_pulse_w),
        .sh_wait_post (sh_wait_post),
        .sh_lines     (sh_lines),
        .sh_div       (sh_div),
        .nx_wait_post (nx_wait_post)
    );

    lcd_pix_div #(.DW(DW)) u_div (
        .clk    (clk),
        .rst    (rst),
        .div    (sh_div),
        .pix_ce (pix_ce)
    );

    lcd_line_fsm #(.XW(XW), .WW(WW), .PW(PW), .LW(LW)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .pix_ce       (pix_ce),
        .xmax         (sh_xmax),
        .wait_pre     (sh_wait_pre),
        .pulse_w      (sh_pulse_w),
        .wait_post    (sh_wait_post),
        .lines        (sh_lines),
        .nx_wait_post (nx_wait_post),
        .frame_end    (frame_end),
        .line_pulse   (line_pulse),
        .frame_mark   (frame_mark),
        .data_act     (data_act)
    );

endmodule

// File: rtl/lcd_line_timer_chk.sv
module lcd_line_timer_chk (
    input logic clk,
    input logic rst,
    input logic pix_ce,
    input logic line_pulse,
    input logic frame_mark,
    input logic data_act
);
    assert_ce_gap_R1: assert property (@(posedge clk) disable iff (rst)
        pix_ce |=> !pix_ce);

    assert_reset_idle_R2: assert property (@(posedge clk)
        $past(rst) |-> (!line_pulse && !frame_mark && !data_act));

    assert_pulse_min_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(line_pulse) |=> line_pulse);

    assert_mark_in_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        frame_mark |-> line_pulse);

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(line_pulse && data_act));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(pix_ce) |-> ($stable(line_pulse) && $stable(data_act) && $stable(frame_mark)));

endmodule

bind lcd_line_timer lcd_line_timer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .pix_ce     (pix_ce),
    .line_pulse (line_pulse),
    .frame_mark (frame_mark),
    .data_act   (data_act)
);

// File: tb/lcd_line_timer_tb.sv
`timescale 1ns/1ps
module lcd_line_timer_tb;
    localparam int XW = 10;
    localparam int WW = 8;
    localparam int PW = 8;
    localparam int LW = 10;
    localparam int DW = 6;
    localparam int NF = 18;

    typedef struct {
        int xmax;
        int wpre;
        int pw;
        int wpost;
        int lines;
        int div;
    } cfg_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [XW-1:0] cfg_xmax;
    logic [WW-1:0] cfg_wait_pre;
    logic [PW-1:0] cfg_pulse_w;
    logic [WW-1:0] cfg_wait_post;
    logic [LW-1:0] cfg_lines;
    logic [DW-1:0] cfg_div;
    logic pix_ce, line_pulse, frame_mark, data_act;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    bit change_pending = 1'b0;
    cfg_t next_cfg;

    always #2.5 clk = ~clk;

    lcd_line_timer #(.XW(XW), .WW(WW), .PW(PW), .LW(LW), .DW(DW)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_xmax(cfg_xmax), .cfg_wait_pre(cfg_wait_pre), .cfg_pulse_w(cfg_pulse_w),
        .cfg_wait_post(cfg_wait_post), .cfg_lines(cfg_lines), .cfg_div(cfg_div),
        .pix_ce(pix_ce), .line_pulse(line_pulse), .frame_mark(frame_mark), .data_act(data_act)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic cfg_t pick(input int idx);
        cfg_t c;
        case (idx)
            0: c = '{xmax: 4, wpre: 2, pw: 2, wpost: 3, lines: 2, div: 1};
            1: c = '{xmax: 1, wpre: 0, pw: 0, wpost: 0, lines: 1, div: 0};
            2: c = '{xmax: 0, wpre: 3, pw: 1, wpost: 0, lines: 3, div: 2};
            3: c = '{xmax: 5, wpre: 0, pw: 3, wpost: 2, lines: 0, div: 0};
            default: begin
                c.xmax  = int'($urandom_range(0, 24));
                c.wpre  = int'($urandom_range(0, 5));
                c.pw    = int'($urandom_range(0, 4));
                c.wpost = int'($urandom_range(0, 5));
                c.lines = int'($urandom_range(0, 4));
                c.div   = int'($urandom_range(0, 3));
            end
        endcase
        return c;
    endfunction

    function automatic int atleast1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic apply(input cfg_t c);
        cfg_xmax      = XW'(c.xmax);
        cfg_wait_pre  = WW'(c.wpre);
        cfg_pulse_w   = PW'(c.pw);
        cfg_wait_post = WW'(c.wpost);
        cfg_lines     = LW'(c.lines);
        cfg_div       = DW'(c.div);
    endtask

    // wait for the next pixel clock and compare the outputs seen during it
    task automatic tick(input string tag, input bit e_lp, input bit e_fm, input bit e_da,
                        input int div, input bit gap_ok);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (pix_ce !== 1'b1);
        chk({tag, " line_pulse"}, int'(line_pulse), int'(e_lp));
        chk({tag, " frame_mark R7"}, int'(frame_mark), int'(e_fm));
        chk({tag, " data_act"}, int'(data_act), int'(e_da));
        chk("R9 pulse/data exclusive", int'(line_pulse && data_act), 0);
        if (gap_ok)
            chk("R1 pixel clock period", n, 2 * (div + 1));
        if (change_pending) begin
            apply(next_cfg);   // mid-frame rewrite, must wait for the boundary (R8)
            change_pending = 1'b0;
        end
    endtask

    initial begin
        cfg_t cur;
        bit gap_ok;
        string t_lead, t_data, t_trail, t_pulse;
        void'($urandom(32'd7321));
        cur = pick(0);
        apply(cur);
        repeat (4) @(negedge clk);
        chk("R2 reset line_pulse", int'(line_pulse), 0);
        chk("R2 reset frame_mark", int'(frame_mark), 0);
        chk("R2 reset data_act", int'(data_act), 0);
        rst = 1'b0;
        gap_ok = 1'b0;
        for (int f = 0; f < NF; f++) begin
            next_cfg = pick(f + 1);
            change_pending = 1'b1;
            for (int l = 0; l < atleast1(cur.lines); l++) begin
                t_lead  = (f == 0 && l == 0) ? "R2 lead" : ((f > 0 && l == 0) ? "R8 lead" : "R6 lead");
                t_data  = (f > 0 && l == 0) ? "R8 data" : "R3 data";
                t_trail = (f > 0 && l == 0) ? "R8 trail" : "R4 trail";
                t_pulse = (f > 0 && l == 0) ? "R8 pulse" : "R5 pulse";
                for (int i = 0; i < ((f == 0 && l == 0) ? atleast1(cur.wpost) : cur.wpost); i++) begin
                    tick(t_lead, 1'b0, 1'b0, 1'b0, cur.div, gap_ok);
                    gap_ok = 1'b1;
                end
                for (int i = 0; i < atleast1(cur.xmax); i++)
                    tick(t_data, 1'b0, 1'b0, 1'b1, cur.div, gap_ok);
                for (int i = 0; i < cur.wpre; i++)
                    tick(t_trail, 1'b0, 1'b0, 1'b0, cur.div, gap_ok);
                for (int i = 0; i < atleast1(cur.pw); i++)
                    tick(t_pulse, 1'b1, (l == atleast1(cur.lines) - 1), 1'b0, cur.div, gap_ok);
            end
            cur = next_cfg;
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R2 actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule